// File: doc/BRIEF.md
# Auto-Refresh Deferral Arbiter

This block decides when a pending auto-refresh may run on a shared memory bus. A refresh-interval timer sends a one-cycle compare-match pulse. The block records it in a single pending flag and holds the refresh back until the bus reaches a legal boundary. A boundary is legal when no access cycle is running and no indivisible sequence is in progress. The indivisible sequences are a narrow-port split access, a 32-byte burst, the gap between the read and write halves of an atomic test-and-set, and the gap inside a dual-address DMA move. The bus must also be held by the local master.

At a legal boundary the block raises a refresh-start strobe for one clock and clears the flag. Only one refresh can wait at a time. A second match that arrives while one is still waiting replaces the older request, and the block reports the lost request with a drop pulse. The block also grants the bus to an external master through an active-low acknowledge. It withdraws that acknowledge (drives it high) as soon as a refresh is waiting, so the external master knows to hand the bus back.

Every pin is a plain level or pulse control signal. The block moves no data and has no handshake, so no pin applies back-pressure.

Top module: `refresh_defer_arb`

## Requirements
- R1: While reset is active and right after it, `refresh_start_o`=0, `refresh_pending_o`=0 and `req_drop_o`=0. `bus_ack_n_o`=1, meaning the local master owns the bus.
- R2: A cycle with `cnt_match_i`=1 makes `refresh_pending_o`=1 from the next clock.
- R3: `refresh_start_o` is combinational. It is 1 exactly when all of these hold: the request is pending, `cyc_busy_i`=0, no enabled bit of `seq_hold_i` is 1, and the bus is owned locally. After the start cycle the pending flag is 0 unless a match came in that same cycle, so each request gives one single-cycle strobe.
- R4: While `cyc_busy_i`=1 a pending refresh does not start.
- R5: While `seq_hold_i` bit 0 (narrow-port split in progress) is 1, a pending refresh does not start.
- R6: While `seq_hold_i` bit 1 (32-byte burst in progress) is 1, a pending refresh does not start.
- R7: While `seq_hold_i` bit 2 (atomic read-to-write gap) or bit 3 (dual-address DMA gap) is 1, a pending refresh does not start.
- R8: While the bus is lent to the external master, a pending refresh waits. It can start in the first cycle after `ext_req_i` falls, once the bus is owned again.
- R9: A match that arrives while a request is pending and no start happens in that cycle raises `req_drop_o` for that cycle. One request stays pending, and only one start results.
- R10: A match that arrives in the same cycle as a start gives no drop. The new request is pending afterwards.
- R11: `bus_ack_n_o` is 0 only while the bus is lent and no refresh is pending. When a refresh becomes pending during a loan, it goes to 1 in the same cycle that `refresh_pending_o` rises.
- R12: The bus is lent on the clock after a cycle in which all of these hold: `ext_req_i`=1, nothing is pending, there is no match, `cyc_busy_i`=0 and no hold bit is 1. It is taken back on the clock after a cycle in which `ext_req_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_match_i | input | 1 | One-cycle refresh-interval match pulse |
| cyc_busy_i | input | 1 | A bus access cycle is in progress |
| seq_hold_i | input | N_HOLD | Indivisible sequence flags: split, burst, atomic, dual DMA |
| ext_req_i | input | 1 | External master requests the bus |
| refresh_start_o | output | 1 | One-cycle strobe that starts a refresh |
| refresh_pending_o | output | 1 | A refresh request is waiting |
| req_drop_o | output | 1 | A waiting request was overwritten by a new match |
| bus_ack_n_o | output | 1 | Active-low bus acknowledge to the external master |

## Verification
Two events can fall in the same cycle: a new counter match, and the start of the refresh that is already waiting. The bench provokes this by placing a match pulse exactly on the first idle cycle after a busy or hold period. It then checks that no drop is reported and that the flag is still set on the next clock (R10). The opposite case, a match during a hold, must report a drop. A reference model in the bench predicts every output on every cycle.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  // Bit positions inside the sequence-hold vector
  localparam int unsigned HOLD_SPLIT  = 0;
  localparam int unsigned HOLD_BURST  = 1;
  localparam int unsigned HOLD_ATOMIC = 2;
  localparam int unsigned HOLD_DUAL   = 3;
  localparam int unsigned HOLD_COUNT  = 4;

  typedef enum logic [0:0] {
    OWN_LOCAL = 1'b0,
    OWN_LENT  = 1'b1
  } owner_e;
endpackage

// File: rtl/rfd_boundary.sv
module rfd_boundary #(
  parameter int unsigned N_HOLD    = rfd_pkg::HOLD_COUNT,
  parameter logic [N_HOLD-1:0] HOLD_MASK = '1
) (
  input  logic              cyc_busy_i,
  input  logic [N_HOLD-1:0] seq_hold_i,
  output logic              quiet_o
);
  logic [N_HOLD-1:0] hold_eff;

  // Each hold source can be compiled out through the mask
  for (genvar g = 0; g < N_HOLD; g++) begin : g_hold
    if (HOLD_MASK[g]) begin : g_on
      assign hold_eff[g] = seq_hold_i[g];
    end else begin : g_off
      assign hold_eff[g] = 1'b0;
    end
  end

  assign quiet_o = !cyc_busy_i && (hold_eff == '0);
endmodule

// File: rtl/rfd_pending.sv
module rfd_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic take_i,
  output logic pend_o,
  output logic drop_o
);
  logic pend_q;

  // A new match always wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (match_i) pend_q <= 1'b1;
    else if (take_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign drop_o = match_i && pend_q && !take_i;
endmodule

// File: rtl/rfd_owner.sv
module rfd_owner (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req_i,
  input  logic can_lend_i,
  output logic lent_o
);
  import rfd_pkg::*;
  owner_e own_q, own_d;

  always_comb begin
    own_d = own_q;
    unique case (own_q)
      OWN_LOCAL: if (ext_req_i && can_lend_i) own_d = OWN_LENT;
      OWN_LENT:  if (!ext_req_i)              own_d = OWN_LOCAL;
      default:   own_d = OWN_LOCAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_LOCAL;
    else        own_q <= own_d;
  end

  assign lent_o = (own_q == OWN_LENT);
endmodule

// File: rtl/refresh_defer_arb.sv
module refresh_defer_arb #(
  parameter int unsigned N_HOLD = rfd_pkg::HOLD_COUNT,
  parameter logic [N_HOLD-1:0] HOLD_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_match_i,
  input  logic              cyc_busy_i,
  input  logic [N_HOLD-1:0] seq_hold_i,
  input  logic              ext_req_i,
  output logic              refresh_start_o,
  output logic              refresh_pending_o,
  output logic              req_drop_o,
  output logic              bus_ack_n_o
);
  logic quiet, pend, lent, take, can_lend;

  rfd_boundary #(.N_HOLD(N_HOLD), .HOLD_MASK(HOLD_MASK)) u_bnd (
    .cyc_busy_i (cyc_busy_i),
    .seq_hold_i (seq_hold_i),
    .quiet_o    (quiet)
  );

  rfd_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .match_i (cnt_match_i),
    .take_i  (take),
    .pend_o  (pend),
    .drop_o  (req_drop_o)
  );

  rfd_owner u_own (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_req_i  (ext_req_i),
    .can_lend_i (can_lend),
    .lent_o     (lent)
  );

  assign take     = pend && quiet && !lent;
  assign can_lend = !pend && !cnt_match_i && quiet;

  assign refresh_start_o   = take;
  assign refresh_pending_o = pend;
  assign bus_ack_n_o       = !(lent && !pend);
endmodule

// File: rtl/rfd_checker.sv
module rfd_checker #(
  parameter int unsigned N_HOLD = rfd_pkg::HOLD_COUNT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_match_i,
  input logic              cyc_busy_i,
  input logic [N_HOLD-1:0] seq_hold_i,
  input logic              ext_req_i,
  input logic              refresh_start_o,
  input logic              refresh_pending_o,
  input logic              req_drop_o,
  input logic              bus_ack_n_o
);
  AST_MATCH_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_match_i |=> refresh_pending_o); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_start_o && !cnt_match_i |=> !refresh_start_o && !refresh_pending_o); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_busy_i |-> !refresh_start_o); // R4
  AST_NO_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_hold_i != '0) |-> !refresh_start_o); // R5
  AST_NO_START_LENT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n_o |-> !refresh_start_o); // R8
  AST_DROP_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    req_drop_o |-> refresh_pending_o && cnt_match_i && !refresh_start_o); // R9
  AST_SAME_CYCLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_start_o && cnt_match_i |-> !req_drop_o ##1 refresh_pending_o); // R10
  AST_ACK_WITHDRAWN: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pending_o |-> bus_ack_n_o); // R11
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_req_i |=> bus_ack_n_o); // R12
endmodule

bind refresh_defer_arb rfd_checker #(.N_HOLD(N_HOLD)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cnt_match_i       (cnt_match_i),
  .cyc_busy_i        (cyc_busy_i),
  .seq_hold_i        (seq_hold_i),
  .ext_req_i         (ext_req_i),
  .refresh_start_o   (refresh_start_o),
  .refresh_pending_o (refresh_pending_o),
  .req_drop_o        (req_drop_o),
  .bus_ack_n_o       (bus_ack_n_o)
);

// File: tb/sim_refresh_defer_arb.sv
`timescale 1ns/1ps
module sim_refresh_defer_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic match = 1'b0, busy = 1'b0, ereq = 1'b0;
  logic [3:0] hold = 4'b0;
  logic start, pend, drop, ack_n;

  int total = 0;
  int bad = 0;
  int m_pend = 0;
  int m_lent = 0;

  always #2.5 clk = ~clk;

  refresh_defer_arb u0 (
    .clk(clk), .rst_n(rst_n), .cnt_match_i(match), .cyc_busy_i(busy),
    .seq_hold_i(hold), .ext_req_i(ereq), .refresh_start_o(start),
    .refresh_pending_o(pend), .req_drop_o(drop), .bus_ack_n_o(ack_n)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle, compare against the reference model, then advance it
  task automatic step(input logic m, input logic b, input logic [3:0] h,
                      input logic e, input string tag);
    int quiet, e_start, e_drop, e_ack;
    @(negedge clk);
    match = m; busy = b; hold = h; ereq = e;
    #1;
    quiet   = (!b && h == 4'b0) ? 1 : 0;
    e_start = (m_pend != 0 && quiet != 0 && m_lent == 0) ? 1 : 0;
    e_drop  = (m && m_pend != 0 && e_start == 0) ? 1 : 0;
    e_ack   = (m_lent != 0 && m_pend == 0) ? 0 : 1;
    chk(tag, "start", start, e_start[0]);
    chk(tag, "pending", pend, m_pend[0]);
    chk(tag, "drop", drop, e_drop[0]);
    chk(tag, "ack_n", ack_n, e_ack[0]);
    @(posedge clk);
    if (m_lent != 0) m_lent = e ? 1 : 0;
    else m_lent = (e && m_pend == 0 && !m && quiet != 0) ? 1 : 0;
    if (m) m_pend = 1;
    else if (e_start != 0) m_pend = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'b0, 1'b0, tag);
  endtask

  initial begin
    #40000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset values
    #12;
    chk("R1", "start", start, 1'b0);
    chk("R1", "pending", pend, 1'b0);
    chk("R1", "drop", drop, 1'b0);
    chk("R1", "ack_n", ack_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R1");

    // R2, R3: plain request starts at the first idle cycle
    step(1'b1, 1'b0, 4'b0, 1'b0, "R2");
    idle(3, "R3");

    // R4: access cycle defers
    step(1'b1, 1'b1, 4'b0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 4'b0, 1'b0, "R4");
    idle(2, "R4");

    // R5, R6, R7: each hold bit defers
    for (int b = 0; b < 4; b++) begin
      string t;
      t = (b == 0) ? "R5" : (b == 1) ? "R6" : "R7";
      step(1'b1, 1'b0, 4'b1 << b, 1'b0, t);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'b1 << b, 1'b0, t);
      idle(2, t);
    end

    // R9: repeated matches during a burst collapse to one request
    step(1'b1, 1'b0, 4'b0010, 1'b0, "R9");
    step(1'b1, 1'b0, 4'b0010, 1'b0, "R9");
    step(1'b1, 1'b0, 4'b0010, 1'b0, "R9");
    idle(3, "R9");

    // R10: match lands on the start cycle
    step(1'b1, 1'b1, 4'b0, 1'b0, "R10");
    step(1'b0, 1'b1, 4'b0, 1'b0, "R10");
    step(1'b1, 1'b0, 4'b0, 1'b0, "R10");
    idle(3, "R10");

    // R12: lending waits for quiet, reclaimed when request falls
    step(1'b0, 1'b1, 4'b0, 1'b1, "R12");
    step(1'b0, 1'b0, 4'b0100, 1'b1, "R12");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 4'b0, 1'b1, "R12");
    step(1'b0, 1'b0, 4'b0, 1'b0, "R12");
    idle(2, "R12");

    // R8, R11: refresh during a loan withdraws ack, waits for return
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 4'b0, 1'b1, "R11");
    step(1'b1, 1'b0, 4'b0, 1'b1, "R11");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 4'b0, 1'b1, "R8");
    step(1'b0, 1'b0, 4'b0, 1'b0, "R8");
    idle(3, "R8");

    // R12: no lending while a request is pending or arriving
    step(1'b1, 1'b1, 4'b0, 1'b1, "R12");
    step(1'b0, 1'b0, 4'b0, 1'b1, "R12");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 4'b0, 1'b1, "R12");
    idle(3, "R12");

    // Mixed pattern
    for (int i = 0; i < 40; i++)
      step((i % 7) == 0, (i % 3) == 1, 4'((i * 5) % 16) & {3'b0, (i % 4) == 2}, (i % 11) > 6, "R3");
    idle(4, "R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule